// File: doc/BRIEF.md
# Host-side terminator for inbound DMA bursts

This block sits on the host end of a source-synchronous DMA link in which the device sends and the host receives. It grants a burst by asserting the acknowledge line (active low). Every transition of the device strobe is taken as one 16-bit word. When the local receiver wants the burst to end, the block pauses the device by releasing its ready line. It then accepts the few trailing words that the cable round trip still delivers. After a programmable settle window it raises the stop line and drives its checksum onto the data bus. When the device has parked its strobe high and dropped its request, and both minimum delays have expired, it releases the acknowledge line.

After the release, a guard window keeps stop asserted and ready released, and keeps the register-access path blocked. When that window expires, a one-cycle done pulse lets the register interface resume. All delays are cycle counts on input ports, so firmware can retune them for each transfer speed. The checksum value comes from outside the block.

The number of trailing words allowed after the pause depends on timing. If the pause took effect soon after the last strobe edge, only one extra word is allowed; if it came later, two are allowed. A strobe edge beyond that allowance is dropped and sets a sticky error flag.

Top module: `tdt_host_term`

## Requirements
- R1: After reset, `dmack_n` and `hrdy_n` are 1, `stop`, `crc_oe`, `overrun`, `done` and `word_valid` are 0, and `regs_ok` is 1.
- R2: A `start` pulse while idle (`regs_ok`=1) drives `dmack_n` and `hrdy_n` to 0 from the next cycle and clears `overrun`.
- R3: While the burst runs, every change of `dev_strobe` level (rising or falling) sampled at a clock edge yields `word_valid`=1 with `word_data` equal to `rx_data` at that edge, one cycle later.
- R4: `term_req` has no effect until at least one word of the current burst has been taken (a word taken at the same edge counts).
- R5: Once termination is accepted, `hrdy_n` is 1 from the next cycle and stays 1 until the block is idle again.
- R6: Let d be the number of clock edges from the edge that sampled the last burst word to the edge that accepts termination (0 when they coincide). If d ≤ `t_sr`, one trailing word is allowed; otherwise two are allowed. Extra strobe edges during the pause produce no word and set `overrun`, which stays set until the next `start`.
- R7: `stop` rises max(`t_rfs`,1) edges after termination is accepted. From that cycle `crc_oe` is 1 and `bus_out` equals `crc_in`. Strobe edges seen after `stop` rises produce no word.
- R8: `dmack_n` returns to 1 only at an edge where `dev_strobe`=1 and `dev_req`=0 have held, with `stop` up, for at least `t_mli` earlier edges, and at least `t_dvs` edges after `stop` rose.
- R9: After `dmack_n` rises, `stop` stays 1, `hrdy_n` stays 1 and `regs_ok` stays 0 for max(`t_ack`,1) cycles. Then `stop` falls, `regs_ok` rises and `done` pulses for exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Grant a new inbound burst |
| term_req | input | 1 | Local request to end the burst |
| dev_strobe | input | 1 | Device strobe level (each change is a word) |
| dev_req | input | 1 | Device DMA request level |
| rx_data | input | DW | Data bus value from the device |
| crc_in | input | DW | Host checksum to present at the end |
| t_sr | input | CW | Edges after a strobe edge still counting as an early pause |
| t_rfs | input | CW | Pause window before stop is raised |
| t_mli | input | CW | Minimum edges the device end condition must hold |
| t_dvs | input | CW | Minimum edges the checksum is on the bus before release |
| t_ack | input | CW | Guard cycles after acknowledge release |
| dmack_n | output | 1 | Burst acknowledge, active low |
| hrdy_n | output | 1 | Host ready, active low |
| stop | output | 1 | Stop request to the device |
| crc_oe | output | 1 | Host drives `bus_out` onto the data bus |
| bus_out | output | DW | Checksum word while `crc_oe` is 1, else 0 |
| word_valid | output | 1 | Received word available |
| word_data | output | DW | Received word |
| overrun | output | 1 | Sticky: a strobe edge beyond the trailing allowance |
| regs_ok | output | 1 | Register access lines may be used |
| done | output | 1 | One-cycle pulse when the guard window ends |

## Verification
The collision of interest is a strobe edge landing on the same clock edge that accepts termination. That edge must still deliver a burst word, and it must count as a pause taken with zero delay, so only one trailing word is allowed. The bench provokes this by toggling the strobe and raising `term_req` in the same cycle, then sending one trailing edge. It judges the result through the scoreboard: both words must arrive in order and `overrun` must stay clear. The neighbouring cases d = `t_sr` and d = `t_sr`+1 are run in separate bursts so that the exact boundary of the allowance is checked.

// File: rtl/tdt_pkg.sv
// Shared types for the inbound-burst terminator.
// Assumes: nothing beyond IEEE 1800-2017.
package tdt_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,   // no burst, register path free
        ST_BURST,  // words flowing, host ready
        ST_PAUSE,  // ready released, trailing words allowed
        ST_STOP,   // stop raised, checksum on the bus
        ST_HOLD    // acknowledge released, guard window
    } tdt_state_e;
endpackage

// File: rtl/tdt_sat_cnt.sv
// Saturating up-counter with synchronous clear.
// Assumes: clr has priority over inc; the value sticks at all ones.
module tdt_sat_cnt #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         inc,
    output logic [W-1:0] q
);
    localparam logic [W-1:0] MAXV = '1;

    // count up, clear on request, hold at the top
    always_ff @(posedge clk) begin
        if (!rst_n || clr)            q <= '0;
        else if (inc && q != MAXV)    q <= q + 1'b1;
    end
endmodule

// File: rtl/tdt_strobe_trk.sv
// Detects strobe level changes, times the gap since the last one and
// captures accepted words.
// Assumes: strobe is already synchronous to clk; level 0 after reset.
module tdt_strobe_trk #(
    parameter int DW = 16,
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          strobe,
    input  logic [DW-1:0] data,
    input  logic          accept,
    output logic          edge_now,
    output logic [CW-1:0] since_q,
    output logic          word_valid,
    output logic [DW-1:0] word_data
);
    logic strobe_q;

    // remember previous strobe level
    always_ff @(posedge clk) begin
        if (!rst_n) strobe_q <= 1'b0;
        else        strobe_q <= strobe;
    end

    // any level change is one word
    always_comb edge_now = strobe ^ strobe_q;

    // edges elapsed since the last strobe change (0 right after it)
    tdt_sat_cnt #(.W(CW)) i_since (
        .clk(clk), .rst_n(rst_n), .clr(edge_now), .inc(1'b1), .q(since_q)
    );

    // register accepted words
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word_valid <= 1'b0;
            word_data  <= '0;
        end else begin
            word_valid <= edge_now && accept;
            if (edge_now && accept) word_data <= data;
        end
    end
endmodule

// File: rtl/tdt_host_term.sv
// Top: host-side sequencer that grants, pauses and closes an inbound
// burst, limits trailing words and times the release and guard windows.
// Assumes: all inputs synchronous to clk; delay inputs stable per burst.
module tdt_host_term
    import tdt_pkg::*;
#(
    parameter int DW = 16,
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          term_req,
    input  logic          dev_strobe,
    input  logic          dev_req,
    input  logic [DW-1:0] rx_data,
    input  logic [DW-1:0] crc_in,
    input  logic [CW-1:0] t_sr,
    input  logic [CW-1:0] t_rfs,
    input  logic [CW-1:0] t_mli,
    input  logic [CW-1:0] t_dvs,
    input  logic [CW-1:0] t_ack,
    output logic          dmack_n,
    output logic          hrdy_n,
    output logic          stop,
    output logic          crc_oe,
    output logic [DW-1:0] bus_out,
    output logic          word_valid,
    output logic [DW-1:0] word_data,
    output logic          overrun,
    output logic          regs_ok,
    output logic          done
);
    localparam int EW = CW + 1;

    tdt_state_e    state_q, state_d;
    logic          has_word, limit_two;
    logic [1:0]    trail_cnt;
    logic          edge_now, accept, dev_end, release_ok, term_ok;
    logic [CW-1:0] since_q, phase_q, mli_q;
    logic [EW-1:0] elapsed;

    tdt_strobe_trk #(.DW(DW), .CW(CW)) i_trk (
        .clk(clk), .rst_n(rst_n), .strobe(dev_strobe), .data(rx_data),
        .accept(accept), .edge_now(edge_now), .since_q(since_q),
        .word_valid(word_valid), .word_data(word_data)
    );

    // cycles spent in the current state, cleared on every transition
    tdt_sat_cnt #(.W(CW)) i_phase (
        .clk(clk), .rst_n(rst_n), .clr(state_d != state_q), .inc(1'b1),
        .q(phase_q)
    );

    // edges the device end condition has held while stop is up
    tdt_sat_cnt #(.W(CW)) i_mli (
        .clk(clk), .rst_n(rst_n), .clr(!(dev_end && state_q == ST_STOP)),
        .inc(1'b1), .q(mli_q)
    );

    // derived conditions for the sequencer
    always_comb begin
        elapsed    = {1'b0, phase_q} + EW'(1);
        accept     = (state_q == ST_BURST) ||
                     (state_q == ST_PAUSE && trail_cnt < (limit_two ? 2'd2 : 2'd1));
        dev_end    = dev_strobe && !dev_req;
        term_ok    = term_req && (has_word || edge_now);
        release_ok = dev_end && (mli_q >= t_mli) && (elapsed >= {1'b0, t_dvs});
    end

    // next-state selection
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (start)                        state_d = ST_BURST;
            ST_BURST: if (term_ok)                      state_d = ST_PAUSE;
            ST_PAUSE: if (elapsed >= {1'b0, t_rfs})     state_d = ST_STOP;
            ST_STOP:  if (release_ok)                   state_d = ST_HOLD;
            ST_HOLD:  if (elapsed >= {1'b0, t_ack})     state_d = ST_IDLE;
            default:                                    state_d = ST_IDLE;
        endcase
    end

    // state, burst bookkeeping, trailing allowance and error flag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= ST_IDLE;
            has_word  <= 1'b0;
            limit_two <= 1'b0;
            trail_cnt <= '0;
            overrun   <= 1'b0;
            done      <= 1'b0;
        end else begin
            state_q <= state_d;
            done    <= (state_q == ST_HOLD) && (state_d == ST_IDLE);
            if (state_q == ST_IDLE && start) begin
                has_word <= 1'b0;
                overrun  <= 1'b0;
            end
            if (state_q == ST_BURST && edge_now) has_word <= 1'b1;
            if (state_q == ST_BURST && term_ok) begin
                limit_two <= !(edge_now || since_q < t_sr);
                trail_cnt <= '0;
            end
            if (state_q == ST_PAUSE && edge_now) begin
                if (accept) trail_cnt <= trail_cnt + 2'd1;
                else        overrun   <= 1'b1;
            end
        end
    end

    // line decode from state
    always_comb begin
        dmack_n = (state_q == ST_IDLE) || (state_q == ST_HOLD);
        hrdy_n  = (state_q != ST_BURST);
        stop    = (state_q == ST_STOP) || (state_q == ST_HOLD);
        crc_oe  = (state_q == ST_STOP);
        bus_out = crc_oe ? crc_in : '0;
        regs_ok = (state_q == ST_IDLE);
    end
endmodule

// File: rtl/tdt_checker.sv
// Protocol checks on the terminator ports, attached by bind.
// Assumes: synchronous active-low reset on rst_n.
module tdt_checker #(
    parameter int DW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          start,
    input logic          dev_strobe,
    input logic          dev_req,
    input logic [DW-1:0] crc_in,
    input logic          dmack_n,
    input logic          hrdy_n,
    input logic          stop,
    input logic          crc_oe,
    input logic [DW-1:0] bus_out,
    input logic          word_valid,
    input logic          overrun,
    input logic          regs_ok,
    input logic          done
);
    a_r2_start_grants: assert property (@(posedge clk) disable iff (!rst_n)
        (regs_ok && start) |=> (!dmack_n && !hrdy_n));

    a_r3_word_from_edge: assert property (@(posedge clk) disable iff (!rst_n)
        word_valid |-> ($past(dev_strobe) != $past(dev_strobe, 2)));

    a_r5_pause_held: assert property (@(posedge clk) disable iff (!rst_n)
        (hrdy_n && !regs_ok) |=> (hrdy_n || regs_ok));

    a_r6_overrun_in_pause: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(overrun) |-> (hrdy_n && !dmack_n));

    a_r7_stop_drives_crc: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(stop) |-> (crc_oe && bus_out == crc_in && hrdy_n));

    a_r8_release_conditions: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dmack_n) |-> ($past(dev_strobe) && !$past(dev_req) && $past(stop)));

    a_r9_guard_on_release: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dmack_n) |-> (stop && hrdy_n && !regs_ok));

    a_r9_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (regs_ok && !stop && dmack_n && $past(stop)));
endmodule

bind tdt_host_term tdt_checker #(.DW(DW)) i_chk (
    .clk(clk), .rst_n(rst_n), .start(start), .dev_strobe(dev_strobe),
    .dev_req(dev_req), .crc_in(crc_in), .dmack_n(dmack_n), .hrdy_n(hrdy_n),
    .stop(stop), .crc_oe(crc_oe), .bus_out(bus_out), .word_valid(word_valid),
    .overrun(overrun), .regs_ok(regs_ok), .done(done)
);

// File: tb/test_tdt_host_term.sv
// Scoreboard bench: driver pushes expected words, monitor pops and compares.
module test_tdt_host_term;
    localparam int DW = 16;
    localparam int CW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0, term_req = 1'b0;
    logic          dev_strobe = 1'b0, dev_req = 1'b1;
    logic [DW-1:0] rx_data = '0, crc_in = '0;
    logic [CW-1:0] t_sr = 8'd3, t_rfs = 8'd6, t_mli = 8'd4, t_dvs = 8'd2, t_ack = 8'd5;
    logic          dmack_n, hrdy_n, stop, crc_oe, word_valid, overrun, regs_ok, done;
    logic [DW-1:0] bus_out, word_data;

    int n_chk = 0, n_bad = 0, cyc = 0;
    logic [DW-1:0] exp_q[$];
    logic [DW-1:0] wseq = 16'hA000;

    always #5 clk = ~clk;

    tdt_host_term #(.DW(DW), .CW(CW)) i_tdt_host_term (
        .clk(clk), .rst_n(rst_n), .start(start), .term_req(term_req),
        .dev_strobe(dev_strobe), .dev_req(dev_req), .rx_data(rx_data),
        .crc_in(crc_in), .t_sr(t_sr), .t_rfs(t_rfs), .t_mli(t_mli),
        .t_dvs(t_dvs), .t_ack(t_ack), .dmack_n(dmack_n), .hrdy_n(hrdy_n),
        .stop(stop), .crc_oe(crc_oe), .bus_out(bus_out),
        .word_valid(word_valid), .word_data(word_data), .overrun(overrun),
        .regs_ok(regs_ok), .done(done)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] expv);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, expv);
        end
    endtask

    task automatic report();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    // watchdog: a hung run counts as a failed check
    always @(posedge clk) begin
        cyc++;
        if (cyc > 60000) begin
            chk(1'b0, "watchdog", cyc, 60000);
            report();
        end
    end

    // monitor: compare each delivered word with the scoreboard head
    always @(negedge clk) begin
        if (rst_n && word_valid) begin
            if (exp_q.size() == 0) chk(1'b0, "R3/R6/R7 unexpected word", word_data, 0);
            else begin
                logic [DW-1:0] e;
                e = exp_q.pop_front();
                chk(word_data == e, "R3 word data", word_data, e);
            end
        end
    end

    // send one strobe edge carrying a word; push it when it should arrive
    task automatic send_edge(input bit expect_it);
        wseq = wseq + 1'b1;
        rx_data = wseq;
        dev_strobe = ~dev_strobe;
        if (expect_it) exp_q.push_back(wseq);
    endtask

    // one full burst: nb words, gap d, nt trailing edges
    task automatic burst(input int nb, input int d, input int nt,
                         input int dvs, input int ack, input bit try_early);
        int lim, cnt, hold_len;
        lim = (d <= int'(t_sr)) ? 1 : 2;
        t_dvs = CW'(dvs);
        t_ack = CW'(ack);
        crc_in = 16'h5A00 + DW'(nb * 16 + d);
        dev_req = 1'b1;
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
        chk(!dmack_n && !hrdy_n, "R2 grant", {dmack_n, hrdy_n}, 0);
        chk(!overrun, "R2 overrun cleared", overrun, 0);
        if (try_early) begin
            term_req = 1'b1;
            repeat (3) @(negedge clk);
            chk(!hrdy_n, "R4 term ignored before a word", hrdy_n, 0);
            term_req = 1'b0;
        end
        for (int i = 0; i < nb; i++) begin
            @(negedge clk);
            send_edge(1'b1);
        end
        if (d == 0) term_req = 1'b1;
        else begin
            repeat (d) @(negedge clk);
            term_req = 1'b1;
        end
        cnt = 0;
        for (int i = 0; i < nt; i++) begin
            @(negedge clk);
            cnt++;
            term_req = 1'b0;
            if (i == 0) chk(hrdy_n, "R5 ready released", hrdy_n, 1);
            send_edge(i < lim);
        end
        while (!stop && cnt < 50) begin
            @(negedge clk);
            cnt++;
            term_req = 1'b0;
        end
        chk(cnt == int'(t_rfs) + 1, "R7 stop timing", cnt, int'(t_rfs) + 1);
        chk(crc_oe && bus_out == crc_in, "R7 checksum on bus", bus_out, crc_in);
        chk(overrun == (nt > lim), "R6 overrun flag", overrun, nt > lim);
        chk(exp_q.size() == 0, "R6 trailing words delivered", exp_q.size(), 0);
        // edges after stop: must not deliver words (monitor flags any)
        send_edge(1'b0);
        @(negedge clk) send_edge(1'b0);
        @(negedge clk);
        dev_strobe = 1'b1;
        dev_req = 1'b0;
        cnt = 0;
        while (!dmack_n && cnt < 100) begin
            @(negedge clk);
            cnt++;
            if (!dmack_n) chk(hrdy_n && stop, "R5 pause held until release", {hrdy_n, stop}, 3);
        end
        begin
            int e8;
            e8 = (dvs - 2 > int'(t_mli) + 1) ? dvs - 2 : int'(t_mli) + 1;
            chk(cnt == e8, "R8 release delay", cnt, e8);
        end
        hold_len = 0;
        while (stop && hold_len < 100) begin
            chk(hrdy_n && !regs_ok && !done, "R9 guard lines", {hrdy_n, regs_ok, done}, 4);
            hold_len++;
            @(negedge clk);
        end
        chk(hold_len == ((ack > 1) ? ack : 1), "R9 guard length", hold_len, (ack > 1) ? ack : 1);
        chk(done && regs_ok && dmack_n, "R9 done pulse", {done, regs_ok, dmack_n}, 7);
        @(negedge clk);
        chk(!done, "R9 done one cycle", done, 0);
        dev_req = 1'b1;
        repeat (2) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(dmack_n && hrdy_n && !stop && !crc_oe && !overrun && !done && !word_valid && regs_ok,
            "R1 reset state", {dmack_n, hrdy_n, stop, crc_oe, overrun, done, word_valid, regs_ok}, 8'hC1);
        rst_n = 1'b1;
        @(negedge clk);
        // R6 boundary d = t_sr: one allowed, two sent -> overrun
        burst(3, 3, 2, 2, 5, 1'b1);
        // R6 just past boundary: two allowed, two sent, clean; t_dvs dominates R8
        burst(4, 4, 2, 12, 0, 1'b0);
        // collision: edge and termination at the same edge, one trailing word
        burst(2, 0, 1, 2, 1, 1'b0);
        // late pause, three trailing edges -> two accepted plus overrun
        burst(1, 7, 3, 3, 3, 1'b0);
        report();
    end
endmodule